// File: doc/BRIEF.md
# Compare-Latch Conditional Branch Unit

This unit resolves conditional branches for a processor without a flag register. A compare operation does no arithmetic: it only stores its two 32-bit register values in a pair of internal operand latches. A later branch names one of ten relations, equality, inequality and the four orderings in both signed and unsigned form. The unit evaluates that relation on the stored pair at the moment the branch arrives.

From the outcome and the program counter of the branch, the unit produces the next program counter. A taken branch jumps by a halfword-scaled signed displacement measured from the instruction that follows the branch. A branch that is not taken falls through by one 2-byte instruction. Condition codes that name no relation are reported as illegal, and the program counter of the faulting branch is kept on the result port so an exception handler can pick it up.

Results are registered. A one-cycle valid pulse marks each resolved branch, and the result ports hold their last values until the next branch.

Top module: `cmp_branch_unit`

## Requirements
- R1: A cycle with `cmp_stb` high stores `cmp_lhs` and `cmp_rhs` into the operand latches. A compare by itself changes none of the result outputs, and `res_valid` stays low.
- R2: On a branch, the relation is "stored lhs REL stored rhs". The condition code selects the relation: 0 equal, 1 not equal, 2 signed less, 3 signed greater, 4 unsigned less, 5 unsigned greater, 6 signed greater-or-equal, 7 signed less-or-equal, 8 unsigned greater-or-equal, 9 unsigned less-or-equal.
- R3: A taken branch sets `res_next_pc` to `cur_pc + 2 + (sign_extend(br_disp) << 1)`, where `br_disp` is 10 bits and bit 9 is its sign.
- R4: A branch that is not taken with a legal code sets `res_next_pc` to `cur_pc + 2`.
- R5: Condition codes 10 to 15 set `res_illegal` high and `res_taken` low, and set `res_next_pc` to the `cur_pc` of the faulting branch.
- R6: Reset clears both operand latches. A branch issued before any compare therefore evaluates 0 against 0, so equal is taken and signed less is not taken.
- R7: When `cmp_stb` and `br_stb` are high in the same cycle, the branch uses the operands stored before that cycle. The new operands are used by the next branch.
- R8: `res_valid` is high for exactly the one cycle after each cycle with `br_stb` high. The result outputs change only in that cycle and otherwise hold. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_stb | input | 1 | Compare strobe: store the operand pair |
| cmp_lhs | input | 32 | First compare operand |
| cmp_rhs | input | 32 | Second compare operand |
| br_stb | input | 1 | Branch strobe: resolve a branch this cycle |
| br_cond | input | 4 | Condition code, 0 to 9 legal |
| br_disp | input | 10 | Signed displacement in halfwords |
| cur_pc | input | 32 | Program counter of the branch |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_taken | output | 1 | Branch was taken |
| res_next_pc | output | 32 | Next program counter, or the faulting PC |
| res_illegal | output | 1 | Condition code was illegal |

## Verification
The hardest case to reach from the ports is a compare and a branch in the same cycle. The branch has to see the old operand pair while the latches take the new one. The bench first stores a pair that makes equal false. It then strobes a compare of equal values together with an equal-condition branch, expecting not taken, and follows with a lone branch that must now be taken. Signed and unsigned variants are told apart with operands whose top bits differ, such as 0xFFFFFFFF against 1, where the signed and unsigned orderings disagree.

// File: rtl/cbu_pkg.sv
// Package: shared widths and the condition-code encoding of the
// compare-latch branch unit. Assumes a 4-bit condition field and ten
// legal relations; codes above COND_LAST_LEGAL are illegal.
package cbu_pkg;
    localparam int DATA_W = 32;
    localparam int COND_W = 4;
    localparam int DISP_W = 10;
    localparam int INSN_BYTES = 2;

    typedef enum logic [COND_W-1:0] {
        COND_EQ  = 4'd0,
        COND_NE  = 4'd1,
        COND_SLT = 4'd2,
        COND_SGT = 4'd3,
        COND_ULT = 4'd4,
        COND_UGT = 4'd5,
        COND_SGE = 4'd6,
        COND_SLE = 4'd7,
        COND_UGE = 4'd8,
        COND_ULE = 4'd9
    } cond_e;

    localparam logic [COND_W-1:0] COND_LAST_LEGAL = 4'd9;
endpackage

// File: rtl/cbu_operand_latch.sv
// Module: holds the operand pair of the most recent compare.
// Assumes: synchronous active-low reset clears both operands to zero.
// A compare strobe captures both operands at the clock edge; readers in
// the same cycle see the previously held pair.
module cbu_operand_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] op_a,
    output logic [W-1:0] op_b
);

    // Capture the operand pair on a compare, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a <= '0;
            op_b <= '0;
        end else if (load) begin
            op_a <= in_a;
            op_b <= in_b;
        end
    end

    // R1: a compare stores both operands.
    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (op_a == $past(in_a)) && (op_b == $past(in_b)));

    // R1: without a compare the pair holds.
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(rst_n)) |=> $stable(op_a) && $stable(op_b));

endmodule

// File: rtl/cbu_magnitude.sv
// Module: strict less-than comparator whose signedness is fixed by a
// parameter. Assumes operands of equal width; purely combinational.
module cbu_magnitude #(
    parameter int W          = 32,
    parameter bit SIGNED_CMP = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt
);

    generate
        if (SIGNED_CMP) begin : g_signed
            // Two's-complement ordering.
            always_comb lt = $signed(a) < $signed(b);
        end else begin : g_unsigned
            // Plain magnitude ordering.
            always_comb lt = a < b;
        end
    endgenerate

endmodule

// File: rtl/cbu_relation_eval.sv
// Module: evaluates the selected relation on the stored operand pair.
// Assumes condition encodings from cbu_pkg; codes above the last legal
// code flag an illegal condition and force the outcome to not taken.
module cbu_relation_eval
    import cbu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [COND_W-1:0] cond,
    output logic              taken,
    output logic              illegal
);

    logic eq;
    logic lt_vec [2];   // index 0 unsigned, 1 signed

    // Equality shared by every relation.
    always_comb eq = (op_a == op_b);

    generate
        for (genvar s = 0; s < 2; s++) begin : g_mag
            cbu_magnitude #(.W(W), .SIGNED_CMP(s != 0)) u_mag (
                .a  (op_a),
                .b  (op_b),
                .lt (lt_vec[s])
            );
        end
    endgenerate

    // Select the relation named by the condition code.
    always_comb begin
        taken   = 1'b0;
        illegal = 1'b0;
        case (cond)
            COND_EQ:  taken = eq;
            COND_NE:  taken = !eq;
            COND_SLT: taken = lt_vec[1];
            COND_SGT: taken = !lt_vec[1] && !eq;
            COND_ULT: taken = lt_vec[0];
            COND_UGT: taken = !lt_vec[0] && !eq;
            COND_SGE: taken = !lt_vec[1];
            COND_SLE: taken = lt_vec[1] || eq;
            COND_UGE: taken = !lt_vec[0];
            COND_ULE: taken = lt_vec[0] || eq;
            default:  illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/cbu_target_gen.sv
// Module: forms the fall-through and taken addresses of a branch.
// Assumes a 2-byte branch instruction and a halfword-scaled signed
// displacement measured from the following instruction.
module cbu_target_gen
    import cbu_pkg::*;
#(
    parameter int W  = 32,
    parameter int DW = 10
) (
    input  logic [W-1:0]  pc,
    input  logic [DW-1:0] disp,
    output logic [W-1:0]  seq_pc,
    output logic [W-1:0]  jump_pc
);

    localparam int EXT_W = W - DW - 1;

    logic [W-1:0] offset;

    // Sign-extend and scale the displacement to bytes.
    always_comb offset = {{EXT_W{disp[DW-1]}}, disp, 1'b0};

    // Sequential address and branch target.
    always_comb begin
        seq_pc  = pc + W'(INSN_BYTES);
        jump_pc = seq_pc + offset;
    end

endmodule

// File: rtl/cmp_branch_unit.sv
// Module: compare-latch conditional branch unit (top). A compare stores
// its operand pair; a branch evaluates one of ten relations on the stored
// pair and returns a registered next-PC result with a one-cycle valid.
// Assumes: synchronous active-low reset; a same-cycle compare and branch
// resolves the branch against the pair stored before that cycle.
module cmp_branch_unit
    import cbu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_stb,
    input  logic [DATA_W-1:0] cmp_lhs,
    input  logic [DATA_W-1:0] cmp_rhs,
    input  logic              br_stb,
    input  logic [COND_W-1:0] br_cond,
    input  logic [DISP_W-1:0] br_disp,
    input  logic [DATA_W-1:0] cur_pc,
    output logic              res_valid,
    output logic              res_taken,
    output logic [DATA_W-1:0] res_next_pc,
    output logic              res_illegal
);

    logic [DATA_W-1:0] op_a, op_b;
    logic              rel_taken, rel_illegal;
    logic [DATA_W-1:0] seq_pc, jump_pc;

    cbu_operand_latch #(.W(DATA_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmp_stb),
        .in_a  (cmp_lhs),
        .in_b  (cmp_rhs),
        .op_a  (op_a),
        .op_b  (op_b)
    );

    cbu_relation_eval #(.W(DATA_W)) u_eval (
        .op_a    (op_a),
        .op_b    (op_b),
        .cond    (br_cond),
        .taken   (rel_taken),
        .illegal (rel_illegal)
    );

    cbu_target_gen #(.W(DATA_W), .DW(DISP_W)) u_tgt (
        .pc      (cur_pc),
        .disp    (br_disp),
        .seq_pc  (seq_pc),
        .jump_pc (jump_pc)
    );

    // Register the branch result; hold it between branches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_taken   <= 1'b0;
            res_illegal <= 1'b0;
            res_next_pc <= '0;
        end else begin
            res_valid <= br_stb;
            if (br_stb) begin
                res_illegal <= rel_illegal;
                res_taken   <= rel_taken && !rel_illegal;
                if (rel_illegal)
                    res_next_pc <= cur_pc;
                else if (rel_taken)
                    res_next_pc <= jump_pc;
                else
                    res_next_pc <= seq_pc;
            end
        end
    end

    // R8: valid follows a branch strobe by one cycle.
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        br_stb |=> res_valid);

    // R8: no branch, no valid and no change to the next PC.
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_stb && $past(rst_n)) |=> !res_valid && $stable(res_next_pc)
                                      && $stable(res_taken));

    // R5: an illegal code keeps the faulting PC and is never taken.
    assert_illegal_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_stb && br_cond > COND_LAST_LEGAL) |=>
            res_illegal && !res_taken && (res_next_pc == $past(cur_pc)));

    // R4: a legal, not-taken branch falls through by one instruction.
    assert_fallthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_stb && br_cond <= COND_LAST_LEGAL) |=>
            !res_illegal && (res_taken || res_next_pc == $past(cur_pc) + 32'd2));

    // R2: the equal condition follows the stored operand pair.
    assert_eq_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_stb && br_cond == COND_EQ) |=> res_taken == ($past(op_a) == $past(op_b)));

endmodule

// File: tb/sim_cmp_branch_unit.sv
// Directed bench for cmp_branch_unit: one task per scenario.
module sim_cmp_branch_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_stb = 1'b0;
    logic [31:0] cmp_lhs = '0;
    logic [31:0] cmp_rhs = '0;
    logic        br_stb = 1'b0;
    logic [3:0]  br_cond = '0;
    logic [9:0]  br_disp = '0;
    logic [31:0] cur_pc = '0;
    logic        res_valid;
    logic        res_taken;
    logic [31:0] res_next_pc;
    logic        res_illegal;

    int checks = 0;
    int errors = 0;

    // Bench-side copy of the stored pair, kept from the requirements.
    logic [31:0] mdl_a = '0;
    logic [31:0] mdl_b = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_branch_unit u0 (
        .clk, .rst_n, .cmp_stb, .cmp_lhs, .cmp_rhs, .br_stb, .br_cond,
        .br_disp, .cur_pc, .res_valid, .res_taken, .res_next_pc, .res_illegal
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // Relation per R2 encoding, lhs REL rhs.
    function automatic logic rel(input logic [3:0] c, input logic [31:0] a,
                                 input logic [31:0] b);
        case (c)
            4'd0: return a == b;
            4'd1: return a != b;
            4'd2: return $signed(a) <  $signed(b);
            4'd3: return $signed(a) >  $signed(b);
            4'd4: return a <  b;
            4'd5: return a >  b;
            4'd6: return $signed(a) >= $signed(b);
            4'd7: return $signed(a) <= $signed(b);
            4'd8: return a >= b;
            default: return a <= b;
        endcase
    endfunction

    function automatic logic [31:0] tgt(input logic [31:0] pc, input logic [9:0] d);
        return pc + 32'd2 + ({{22{d[9]}}, d} << 1);
    endfunction

    task automatic do_cmp(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cmp_stb = 1'b1; cmp_lhs = a; cmp_rhs = b;
        @(negedge clk);
        cmp_stb = 1'b0;
        mdl_a = a; mdl_b = b;
    endtask

    // Issue a legal branch and check taken and next PC against the model.
    task automatic do_branch(input string req, input logic [3:0] c,
                             input logic [9:0] d, input logic [31:0] pc);
        logic t;
        t = rel(c, mdl_a, mdl_b);
        @(negedge clk);
        br_stb = 1'b1; br_cond = c; br_disp = d; cur_pc = pc;
        @(negedge clk);
        br_stb = 1'b0;
        check(req, "valid", 32'(res_valid), 32'd1);
        check(req, "taken", 32'(res_taken), 32'(t));
        check(req, "illegal", 32'(res_illegal), 32'd0);
        check(t ? "R3" : "R4", "next_pc", res_next_pc, t ? tgt(pc, d) : pc + 32'd2);
    endtask

    task automatic t_reset;
        check("R8", "reset valid", 32'(res_valid), 32'd0);
        check("R8", "reset taken", 32'(res_taken), 32'd0);
        check("R8", "reset next_pc", res_next_pc, 32'd0);
        check("R8", "reset illegal", 32'(res_illegal), 32'd0);
    endtask

    task automatic t_before_compare_r6;
        do_branch("R6", 4'd0, 10'd4, 32'h100);   // 0 == 0: taken
        do_branch("R6", 4'd2, 10'd4, 32'h200);   // 0 < 0 signed: not taken
    endtask

    task automatic t_compare_only_r1;
        logic [31:0] pc_before;
        pc_before = res_next_pc;
        do_cmp(32'h5, 32'h7);
        check("R1", "valid after compare", 32'(res_valid), 32'd0);
        check("R1", "next_pc unchanged", res_next_pc, pc_before);
        do_branch("R1", 4'd4, 10'd1, 32'h300);   // 5 < 7 uses stored pair
    endtask

    task automatic t_all_conditions_r2;
        logic [31:0] pa [4] = '{32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000, 32'h1234_5678};
        logic [31:0] pb [4] = '{32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h1234_5678};
        for (int p = 0; p < 4; p++) begin
            do_cmp(pa[p], pb[p]);
            for (int c = 0; c < 10; c++)
                do_branch("R2", 4'(c), 10'h3F0, 32'h1000 + 32'(c * 16));
        end
    endtask

    task automatic t_displacement_r3;
        do_cmp(32'd9, 32'd9);
        do_branch("R3", 4'd0, 10'h200, 32'h0000_2000);  // most negative
        do_branch("R3", 4'd0, 10'h1FF, 32'h0000_2000);  // most positive
        do_branch("R3", 4'd9, 10'h3FF, 32'hFFFF_FFFE);  // wraps
    endtask

    task automatic t_illegal_r5;
        for (int c = 10; c < 16; c++) begin
            @(negedge clk);
            br_stb = 1'b1; br_cond = 4'(c); br_disp = 10'h10; cur_pc = 32'hA000 + 32'(c);
            @(negedge clk);
            br_stb = 1'b0;
            check("R5", "illegal", 32'(res_illegal), 32'd1);
            check("R5", "taken", 32'(res_taken), 32'd0);
            check("R5", "fault pc", res_next_pc, 32'hA000 + 32'(c));
        end
    endtask

    task automatic t_same_cycle_r7;
        do_cmp(32'd1, 32'd2);
        @(negedge clk);
        cmp_stb = 1'b1; cmp_lhs = 32'd3; cmp_rhs = 32'd3;
        br_stb = 1'b1; br_cond = 4'd0; br_disp = 10'd8; cur_pc = 32'h4000;
        @(negedge clk);
        cmp_stb = 1'b0; br_stb = 1'b0;
        check("R7", "old pair used", 32'(res_taken), 32'd0);
        check("R7", "fallthrough", res_next_pc, 32'h4002);
        mdl_a = 32'd3; mdl_b = 32'd3;
        do_branch("R7", 4'd0, 10'd8, 32'h4100);         // new pair now: taken
    endtask

    task automatic t_hold_r8;
        logic [31:0] held;
        held = res_next_pc;
        @(negedge clk);
        check("R8", "valid drops", 32'(res_valid), 32'd0);
        cur_pc = 32'h5555_0000; br_cond = 4'd1;
        @(negedge clk);
        check("R8", "next_pc held", res_next_pc, held);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_before_compare_r6();
        t_compare_only_r1();
        t_all_conditions_r2();
        t_displacement_r3();
        t_illegal_r5();
        t_same_cycle_r7();
        t_hold_r8();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule